// File: doc/BRIEF.md
# Multi-Mode Link LED Driver

This block turns a set of network link and traffic status signals into a small number of LED drive pins. Each LED has its own four-bit mode field, which picks one status condition from a sixteen-entry table: a link at a given speed, any link, link with or without traffic, filtered traffic, full duplex, collision, one-lane bus, paused transmit, or a forced on or off level. The LED's invert bit then sets the electrical polarity.

Any LED can also be set to blink. A shared blink generator counts a millisecond tick input and toggles a phase after a slow or a fast half-period, chosen by one global rate bit. Blinking gates the selected condition, so a blinking LED flashes only while its condition holds and stays dark otherwise.

Reset loads every field from configuration inputs. After that, a write port can change the mode, blink and invert fields of one LED, or the global rate, at run time. Each pin is registered.

Top module: `link_led_driver`

## Requirements
- R1: Speed encoding is 00 = 10, 01 = 100, 10 = 1000, 11 = no valid speed. While link is up, mode 0 lights on a 10 or 1000 link, mode 1 on a 100 or 1000 link, mode 2 on any link, mode 5 on 10 only, mode 6 on 100 only and mode 7 on 1000 only. Modes 2, 5, 6 and 7 are dark while link is down, and so are modes 0 and 1.
- R2: Mode 3 lights when link is up and filtered traffic is present. Mode 4 lights when link is up and neither transmit nor receive activity is present. Mode 11 lights when link is up and transmit or receive activity is present.
- R3: Mode 9 follows full duplex, mode 10 follows collision, mode 12 follows the one-lane bus flag and mode 13 follows transmit paused, none of them gated by link. Mode 14 is always lit, and modes 15 and 8 are always dark.
- R4: With invert 0 a lit LED drives its pin low and a dark LED drives it high. With invert 1 the polarity is reversed.
- R5: With blink enabled on a lit condition and one tick every cycle, the pin holds each level for SLOW_MS ticks when the rate bit is 0, and for FAST_MS ticks when it is 1. After a rate change, the next toggle comes within one half-period of the new rate.
- R6: Blink gates the condition: a blinking LED whose condition is false stays dark. A LED with blink disabled holds a steady level.
- R7: The blink phase advances only on cycles where the tick input is high.
- R8: While reset is high, each pin is driven to the dark level of its invert configuration input. Reset loads the mode, blink, invert and rate fields from the configuration inputs, and the blink phase starts in its lit half.
- R9: A field write sampled at one rising edge updates the fields at that edge. The pin shows the new setting from the following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | NUM_LEDS*4 | Reset mode per LED, LED n in bits 4n+3:4n |
| cfg_blink | input | NUM_LEDS | Reset blink enable per LED |
| cfg_invert | input | NUM_LEDS | Reset invert per LED |
| cfg_rate_fast | input | 1 | Reset value of the global blink rate bit |
| wr_en | input | 1 | Write the fields of LED wr_idx |
| wr_idx | input | IDX_W | LED selected for the write |
| wr_mode | input | 4 | New mode |
| wr_blink | input | 1 | New blink enable |
| wr_invert | input | 1 | New invert |
| wr_rate_en | input | 1 | Write the global rate bit |
| wr_rate_fast | input | 1 | New rate bit (1 = fast) |
| ms_tick | input | 1 | One-cycle millisecond tick |
| link_up | input | 1 | Link established |
| link_speed | input | 2 | Speed code as in R1 |
| full_duplex | input | 1 | Full duplex link |
| collision | input | 1 | Collision seen |
| tx_active | input | 1 | Transmit activity |
| rx_active | input | 1 | Receive activity |
| filt_active | input | 1 | Traffic that passed address filtering |
| one_lane | input | 1 | Host bus runs one lane wide |
| tx_paused | input | 1 | Transmitter held by flow control |
| led_pin | output | NUM_LEDS | Registered LED drive pins |

## Verification
The bench builds the block with three LEDs, SLOW_MS = 5 and FAST_MS = 2. The short half-periods make it cheap to measure both blink rates and a rate change, with the tick input held high, in a few dozen cycles. At this size, all sixteen modes can be swept against all 1024 combinations of the ten status bits, on all three LEDs at once, with mixed invert settings. This covers every row of the mode table, including the reserved code and the unused speed code.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    M_LNK_10_1G  = 4'd0,
    M_LNK_100_1G = 4'd1,
    M_LNK_ANY    = 4'd2,
    M_FILT_ACT   = 4'd3,
    M_LNK_IDLE   = 4'd4,
    M_LNK_10     = 4'd5,
    M_LNK_100    = 4'd6,
    M_LNK_1G     = 4'd7,
    M_RSVD       = 4'd8,
    M_FDX        = 4'd9,
    M_COLL       = 4'd10,
    M_TRAFFIC    = 4'd11,
    M_ONE_LANE   = 4'd12,
    M_PAUSED     = 4'd13,
    M_ON         = 4'd14,
    M_OFF        = 4'd15
  } led_mode_e;

  typedef enum logic [1:0] {
    SPD_10   = 2'd0,
    SPD_100  = 2'd1,
    SPD_1G   = 2'd2,
    SPD_NONE = 2'd3
  } speed_e;

  typedef struct packed {
    logic   link_up;
    speed_e speed;
    logic   fdx;
    logic   coll;
    logic   tx_act;
    logic   rx_act;
    logic   filt_act;
    logic   one_lane;
    logic   tx_paused;
  } link_stat_t;

  typedef struct packed {
    led_mode_e mode;
    logic      blink;
    logic      invert;
  } led_cfg_t;

endpackage

// File: rtl/led_source_mux.sv
module led_source_mux
  import led_drv_pkg::*;
(
  input  link_stat_t st,
  input  led_mode_e  mode,
  output logic       src
);

  logic is10, is100, is1g, busy;

  always_comb begin
    is10  = st.link_up && (st.speed == SPD_10);
    is100 = st.link_up && (st.speed == SPD_100);
    is1g  = st.link_up && (st.speed == SPD_1G);
    busy  = st.tx_act || st.rx_act;
    unique case (mode)
      M_LNK_10_1G:  src = is10 || is1g;
      M_LNK_100_1G: src = is100 || is1g;
      M_LNK_ANY:    src = st.link_up;
      M_FILT_ACT:   src = st.link_up && st.filt_act;
      M_LNK_IDLE:   src = st.link_up && !busy;
      M_LNK_10:     src = is10;
      M_LNK_100:    src = is100;
      M_LNK_1G:     src = is1g;
      M_RSVD:       src = 1'b0;
      M_FDX:        src = st.fdx;
      M_COLL:       src = st.coll;
      M_TRAFFIC:    src = st.link_up && busy;
      M_ONE_LANE:   src = st.one_lane;
      M_PAUSED:     src = st.tx_paused;
      M_ON:         src = 1'b1;
      M_OFF:        src = 1'b0;
      default:      src = 1'b0;
    endcase
  end

endmodule

// File: rtl/led_cfg_regs.sv
module led_cfg_regs
  import led_drv_pkg::*;
#(
  parameter int NUM_LEDS = 3,
  localparam int IDX_W = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_LEDS*MODE_W-1:0] cfg_mode,
  input  logic [NUM_LEDS-1:0]        cfg_blink,
  input  logic [NUM_LEDS-1:0]        cfg_invert,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [MODE_W-1:0]          wr_mode,
  input  logic                       wr_blink,
  input  logic                       wr_invert,
  output led_cfg_t                   cfg_q [NUM_LEDS]
);

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[i].mode   <= led_mode_e'(cfg_mode[i*MODE_W +: MODE_W]);
        cfg_q[i].blink  <= cfg_blink[i];
        cfg_q[i].invert <= cfg_invert[i];
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        cfg_q[i].mode   <= led_mode_e'(wr_mode);
        cfg_q[i].blink  <= wr_blink;
        cfg_q[i].invert <= wr_invert;
      end
    end
  end

endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
  parameter int SLOW_MS = 200,
  parameter int FAST_MS = 83,
  localparam int CNT_W = $clog2(SLOW_MS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_tick,
  input  logic fast_sel,
  output logic phase
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  // >= rather than == so a drop to the fast rate never waits for a wrap
  assign last = fast_sel ? CNT_W'(FAST_MS - 1) : CNT_W'(SLOW_MS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      phase <= 1'b1;
    end else if (ms_tick) begin
      if (cnt >= last) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/link_led_driver.sv
module link_led_driver
  import led_drv_pkg::*;
#(
  parameter int NUM_LEDS = 3,
  parameter int SLOW_MS  = 200,
  parameter int FAST_MS  = 83,
  localparam int IDX_W = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_LEDS*MODE_W-1:0] cfg_mode,
  input  logic [NUM_LEDS-1:0]        cfg_blink,
  input  logic [NUM_LEDS-1:0]        cfg_invert,
  input  logic                       cfg_rate_fast,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [MODE_W-1:0]          wr_mode,
  input  logic                       wr_blink,
  input  logic                       wr_invert,
  input  logic                       wr_rate_en,
  input  logic                       wr_rate_fast,
  input  logic                       ms_tick,
  input  logic                       link_up,
  input  logic [1:0]                 link_speed,
  input  logic                       full_duplex,
  input  logic                       collision,
  input  logic                       tx_active,
  input  logic                       rx_active,
  input  logic                       filt_active,
  input  logic                       one_lane,
  input  logic                       tx_paused,
  output logic [NUM_LEDS-1:0]        led_pin
);

  link_stat_t st;
  led_cfg_t   cfg_q [NUM_LEDS];
  logic       rate_fast_q;
  logic       blink_phase;

  assign st = '{link_up:   link_up,
                speed:     speed_e'(link_speed),
                fdx:       full_duplex,
                coll:      collision,
                tx_act:    tx_active,
                rx_act:    rx_active,
                filt_act:  filt_active,
                one_lane:  one_lane,
                tx_paused: tx_paused};

  always_ff @(posedge clk) begin
    if (rst)             rate_fast_q <= cfg_rate_fast;
    else if (wr_rate_en) rate_fast_q <= wr_rate_fast;
  end

  led_cfg_regs #(.NUM_LEDS(NUM_LEDS)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cfg_mode   (cfg_mode),
    .cfg_blink  (cfg_blink),
    .cfg_invert (cfg_invert),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_mode    (wr_mode),
    .wr_blink   (wr_blink),
    .wr_invert  (wr_invert),
    .cfg_q      (cfg_q)
  );

  led_blink_gen #(.SLOW_MS(SLOW_MS), .FAST_MS(FAST_MS)) u_blink (
    .clk      (clk),
    .rst      (rst),
    .ms_tick  (ms_tick),
    .fast_sel (rate_fast_q),
    .phase    (blink_phase)
  );

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
    logic src, lit;

    led_source_mux u_mux (
      .st   (st),
      .mode (cfg_q[i].mode),
      .src  (src)
    );

    assign lit = src && (!cfg_q[i].blink || blink_phase);

    always_ff @(posedge clk) begin
      if (rst) led_pin[i] <= ~cfg_invert[i];
      else     led_pin[i] <= cfg_q[i].invert ? lit : ~lit;
    end
  end

endmodule

// File: rtl/link_led_driver_chk.sv
module link_led_driver_chk
  import led_drv_pkg::*;
#(
  parameter int NUM_LEDS = 3,
  localparam int IDX_W = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_LEDS-1:0] cfg_invert,
  input logic                wr_en,
  input logic [IDX_W-1:0]    wr_idx,
  input logic [MODE_W-1:0]   wr_mode,
  input logic                wr_blink,
  input logic                wr_invert,
  input logic                ms_tick,
  input logic [NUM_LEDS-1:0] led_pin,
  input led_cfg_t            cfg_q [NUM_LEDS],
  input logic                blink_phase
);

  assert_reset_dark_R8: assert property (@(posedge clk)
    $past(rst) |-> (led_pin == ~$past(cfg_invert)));

  assert_phase_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ms_tick)) |-> $stable(blink_phase));

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_chk
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wr_en) && ($past(wr_idx) == IDX_W'(i))) |->
        (cfg_q[i].mode == led_mode_e'($past(wr_mode))) &&
        (cfg_q[i].blink == $past(wr_blink)) &&
        (cfg_q[i].invert == $past(wr_invert)));

    assert_dark_modes_R3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && (($past(cfg_q[i].mode) == M_OFF) || ($past(cfg_q[i].mode) == M_RSVD)))
        |-> (led_pin[i] == ~$past(cfg_q[i].invert)));

    assert_steady_on_R4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && ($past(cfg_q[i].mode) == M_ON) && !$past(cfg_q[i].blink))
        |-> (led_pin[i] == $past(cfg_q[i].invert)));
  end

endmodule

bind link_led_driver link_led_driver_chk #(.NUM_LEDS(NUM_LEDS)) u_chk (.*);

// File: tb/link_led_driver_test.sv
module link_led_driver_test;

  localparam int N    = 3;
  localparam int SLOW = 5;
  localparam int FAST = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst;
  logic [N*4-1:0] cfg_mode;
  logic [N-1:0] cfg_blink, cfg_invert;
  logic         cfg_rate_fast;
  logic         wr_en;
  logic [1:0]   wr_idx;
  logic [3:0]   wr_mode;
  logic         wr_blink, wr_invert, wr_rate_en, wr_rate_fast, ms_tick;
  logic         link_up;
  logic [1:0]   link_speed;
  logic         full_duplex, collision, tx_active, rx_active;
  logic         filt_active, one_lane, tx_paused;
  logic [N-1:0] led_pin;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  link_led_driver #(.NUM_LEDS(N), .SLOW_MS(SLOW), .FAST_MS(FAST)) uut (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic drive_stat(logic [9:0] s);
    link_up     = s[0];
    link_speed  = s[2:1];
    full_duplex = s[3];
    collision   = s[4];
    tx_active   = s[5];
    rx_active   = s[6];
    filt_active = s[7];
    one_lane    = s[8];
    tx_paused   = s[9];
  endtask

  function automatic logic lit_of(int m, logic [9:0] s);
    logic lk = s[0];
    logic [1:0] sp = s[2:1];
    logic busy = s[5] | s[6];
    case (m)
      0:  return lk & (sp == 2'd0 || sp == 2'd2);
      1:  return lk & (sp == 2'd1 || sp == 2'd2);
      2:  return lk;
      3:  return lk & s[7];
      4:  return lk & ~busy;
      5:  return lk & (sp == 2'd0);
      6:  return lk & (sp == 2'd1);
      7:  return lk & (sp == 2'd2);
      9:  return s[3];
      10: return s[4];
      11: return lk & busy;
      12: return s[8];
      13: return s[9];
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic wr(int idx, int m, logic b, logic inv);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 2'(idx); wr_mode = 4'(m); wr_blink = b; wr_invert = inv;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_rate(logic f);
    @(negedge clk);
    wr_rate_en = 1'b1; wr_rate_fast = f;
    @(negedge clk);
    wr_rate_en = 1'b0;
  endtask

  // run length of LED0 in cycles, measured from a transition
  task automatic run_len(output int n);
    logic v;
    v = led_pin[0];
    for (int k = 0; k < 50 && led_pin[0] == v; k++) @(negedge clk);
    v = led_pin[0];
    n = 0;
    for (int k = 0; k < 50 && led_pin[0] == v; k++) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    logic v;
    bit seen_on, seen_off, same;
    rst = 1'b1;
    cfg_mode = {4'h6, 4'h7, 4'h4};
    cfg_blink = 3'b001;
    cfg_invert = 3'b000;
    cfg_rate_fast = 1'b0;
    wr_en = 0; wr_idx = 0; wr_mode = 0; wr_blink = 0; wr_invert = 0;
    wr_rate_en = 0; wr_rate_fast = 0; ms_tick = 0;
    drive_stat(10'b00_0000_0011); // link up, 100
    repeat (4) @(negedge clk);
    chk("R8 pins dark in reset", 32'(led_pin), 32'(3'b111));
    rst = 1'b0;
    @(negedge clk); @(negedge clk);
    // LED0 link-idle blinking in lit phase, LED1 1000 dark, LED2 100 lit
    chk("R8 reset defaults", 32'(led_pin), 32'(3'b010));

    // R9 write timing
    wr(0, 15, 0, 0);
    @(negedge clk);
    chk("R9 setup dark", 32'(led_pin[0]), 32'(1));
    wr_en = 1'b1; wr_idx = 2'd0; wr_mode = 4'd14; wr_blink = 0; wr_invert = 0;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 old value one edge after write", 32'(led_pin[0]), 32'(1));
    @(negedge clk);
    chk("R9 new value two edges after write", 32'(led_pin[0]), 32'(0));

    // R1 R2 R3 R4 full sweep
    for (int m = 0; m < 16; m++) begin
      for (int l = 0; l < N; l++) wr(l, m, 1'b0, l == 1);
      for (int s = 0; s < 1024; s++) begin
        @(negedge clk);
        drive_stat(10'(s));
        @(negedge clk);
        for (int l = 0; l < N; l++) begin
          logic e;
          string tag;
          e = lit_of(m, 10'(s));
          e = (l == 1) ? e : ~e;
          if (l == 1) tag = "R4";
          else if (m <= 2 || (m >= 5 && m <= 7)) tag = "R1";
          else if (m == 3 || m == 4 || m == 11) tag = "R2";
          else tag = "R3";
          chk($sformatf("%s mode=%0d stat=%0h led=%0d", tag, m, s, l),
              32'(led_pin[l]), 32'(e));
        end
      end
    end

    // R5 blink rates
    drive_stat(10'b00_0000_0011);
    wr(0, 14, 1'b1, 1'b1);
    ms_tick = 1'b1;
    run_len(n);
    run_len(n);
    chk("R5 slow half period", 32'(n), 32'(SLOW));
    run_len(n);
    chk("R5 slow half period again", 32'(n), 32'(SLOW));
    set_rate(1'b1);
    run_len(n);
    chk("R5 first toggle after rate change", 32'(n <= SLOW), 32'(1));
    run_len(n);
    chk("R5 fast half period", 32'(n), 32'(FAST));
    run_len(n);
    chk("R5 fast half period again", 32'(n), 32'(FAST));
    set_rate(1'b0);

    // R6 gating and steady
    wr(0, 2, 1'b1, 1'b1);
    @(negedge clk);
    link_up = 1'b0;
    @(negedge clk);
    seen_on = 0;
    for (int k = 0; k < 3*SLOW; k++) begin
      @(negedge clk);
      if (led_pin[0]) seen_on = 1;
    end
    chk("R6 blink with false condition stays dark", 32'(seen_on), 32'(0));
    link_up = 1'b1;
    @(negedge clk);
    seen_on = 0; seen_off = 0;
    for (int k = 0; k < 3*SLOW; k++) begin
      @(negedge clk);
      if (led_pin[0]) seen_on = 1; else seen_off = 1;
    end
    chk("R6 blink with true condition toggles", 32'({seen_on, seen_off}), 32'(2'b11));
    wr(0, 14, 1'b0, 1'b1);
    @(negedge clk);
    seen_off = 0;
    for (int k = 0; k < 3*SLOW; k++) begin
      @(negedge clk);
      if (!led_pin[0]) seen_off = 1;
    end
    chk("R6 blink disabled holds steady", 32'(seen_off), 32'(0));

    // R7 no tick, no toggle
    ms_tick = 1'b0;
    wr(0, 14, 1'b1, 1'b1);
    @(negedge clk);
    v = led_pin[0];
    same = 1;
    for (int k = 0; k < 4*SLOW; k++) begin
      @(negedge clk);
      if (led_pin[0] != v) same = 0;
    end
    chk("R7 phase frozen without tick", 32'(same), 32'(1));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule